// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers 32 level-sensitive interrupt sources and presents them to a processor on two lines: a normal interrupt request and a fast interrupt request. Each source is routed to one of the two by a select mask. Sources on the normal path can be given a priority and a handler address through sixteen programmable vector slots. Sources that no slot covers share a default handler address. Software can also raise any source by writing a software-set register.

The controller keeps a current priority level. When software reads the vector address register at handler entry, the level drops to the most urgent pending level and the old level is saved. When software writes that register at handler exit, the saved level comes back. While a handler runs, only sources of higher priority can raise the normal request again, so handlers can nest.

All configuration, status and acknowledge traffic uses a simple word-addressed register bus. A write takes effect on the clock edge where it is presented. A read returns data combinationally in the same cycle.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the level is idle (17). All slot addresses, slot controls, the default address, the enable, select and software registers are zero, and both request outputs are low.
- R2: The raw word (read at 0x008) is the source input ORed with the software register. Writing 1s to 0x018 sets bits of the software register, writing 1s to 0x01C clears them, and 0 bits leave it unchanged. It reads back at 0x018.
- R3: The enable register (read at 0x010) is set by 1s written to 0x010 and cleared by 1s written to 0x01C-less offset 0x014. The select register at 0x00C is written directly. The normal status (0x000) is raw AND enable AND NOT select. The fast status (0x004) is raw AND select.
- R4: The fast request output is high whenever any raw bit that is also selected is set.
- R5: The normal request output is high when the normal status ANDed with the mask of the current level is nonzero. The mask of the idle level is all ones. Both outputs are registered, so they change one clock after the state or the input that drives them.
- R6: A slot control word (0x200 + 4·n, for slots n = 0..15) holds the enable in bit 5 and the source number in bits 4:0. Slot 0 is the most urgent. The mask of level i is the OR of the source bits of all enabled slots below i, and level 16 covers all enabled slots.
- R7: A read of 0x030 finds the lowest level below the current one whose mask matches a raw bit. If one is found, it saves the current level for that level, makes it current, and returns that level's address. Addresses 0x100 + 4·i serve levels 0..15, and the default at 0x034 serves level 16. If none is found below a non-idle level, the read returns the current level's address and changes nothing.
- R8: A read of 0x030 while idle with no match at any level returns the default address and leaves the level idle.
- R9: A write to 0x030 restores the saved level of the current level, whatever the data. A write while idle leaves the level idle.
- R10: Writes to 0x000 change no state. Reads of unmapped offsets return zero.
- R11: Offsets 0xFE0 to 0xFFC return fixed identification bytes, the least significant byte first. Writes to them have no effect.
- R12: Bit 0 written to 0x020 is stored and reads back. The other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 12 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (needed for the level change on a vector read) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| src_in | input | 32 | Hardware interrupt source levels |
| irq_o | output | 1 | Normal interrupt request, registered |
| fiq_o | output | 1 | Fast interrupt request, registered |

## Verification
Some rules are checked by assertions on every cycle:
- The level never leaves the range 0 to 17.
- Only a vector-address write can raise the level.
- Such a write always raises a non-idle level and leaves an idle level idle.
- Neither output rises while its enable or select mask is empty.
- A write to offset zero changes no state.

Other behaviour needs the bench's scenarios:
- the exact handler address chosen by the level search;
- which level is masked once a handler has been entered;
- the slot enable bit taking a source out of the priority masks;
- set/clear register semantics;
- the one-cycle latency of the outputs.

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int          DW       = 32,
  parameter int          AW       = 12,
  parameter int          NSLOT    = 16,
  parameter logic [63:0] ID_BYTES = 64'h5AC3_0010_2907_4E11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] src_in,
  output logic          irq_o,
  output logic          fiq_o
);
  localparam int SW      = $clog2(DW);
  localparam int SIW     = $clog2(NSLOT);
  localparam int LW      = $clog2(NSLOT + 2);
  localparam int WW      = AW - 2;
  localparam int LV_DEF  = NSLOT;
  localparam int LV_IDLE = NSLOT + 1;

  localparam logic [WW-1:0] O_IRQST = WW'(0);
  localparam logic [WW-1:0] O_FIQST = WW'(1);
  localparam logic [WW-1:0] O_RAW   = WW'(2);
  localparam logic [WW-1:0] O_SEL   = WW'(3);
  localparam logic [WW-1:0] O_ENSET = WW'(4);
  localparam logic [WW-1:0] O_ENCLR = WW'(5);
  localparam logic [WW-1:0] O_SWSET = WW'(6);
  localparam logic [WW-1:0] O_SWCLR = WW'(7);
  localparam logic [WW-1:0] O_PROT  = WW'(8);
  localparam logic [WW-1:0] O_VEC   = WW'(12);
  localparam logic [WW-1:0] O_DFLT  = WW'(13);

  logic [DW-1:0] soft_q, en_q, sel_q;
  logic          prot_q;
  logic [LW-1:0] lvl_q;
  logic [DW-1:0] vaddr_q [NSLOT+1];
  logic [SW:0]   vctl_q  [NSLOT];
  logic [LW-1:0] prev_q  [NSLOT+1];

  logic [DW-1:0] raw, irq_stat, fiq_stat, acc, rd_mux, vec_rd;
  logic [DW-1:0] pmask [NSLOT+2];
  logic [LW-1:0] hit;
  logic          found;

  wire [WW-1:0]  word     = bus_addr[AW-1:2];
  wire [SIW-1:0] slot     = word[SIW-1:0];
  wire           in_vaddr = (word >> SIW) == WW'((256 / 4) >> SIW);
  wire           in_vctl  = (word >> SIW) == WW'((512 / 4) >> SIW);
  wire           in_id    = (word >> 3) == WW'(4064 / 32);
  wire           vec_read = bus_rd && !bus_wr && (word == O_VEC);

  assign raw      = src_in | soft_q;
  assign irq_stat = raw & en_q & ~sel_q;
  assign fiq_stat = raw & sel_q;

  always_comb begin
    acc = '0;
    for (int i = 0; i < NSLOT; i++) begin
      pmask[i] = acc;
      if (vctl_q[i][SW]) acc = acc | (DW'(1) << vctl_q[i][SW-1:0]);
    end
    pmask[NSLOT]   = acc;
    pmask[NSLOT+1] = '1;
  end

  always_comb begin
    hit   = lvl_q;
    found = 1'b0;
    for (int i = 0; i <= NSLOT; i++)
      if (!found && (LW'(i) < lvl_q) && |(raw & pmask[i])) begin
        hit   = LW'(i);
        found = 1'b1;
      end
  end

  assign vec_rd = (hit == LW'(LV_IDLE)) ? vaddr_q[LV_DEF] : vaddr_q[hit];

  always_comb begin
    rd_mux = '0;
    if (in_vaddr)      rd_mux = vaddr_q[slot];
    else if (in_vctl)  rd_mux = DW'(vctl_q[slot]);
    else if (in_id)    rd_mux = DW'(ID_BYTES[{word[2:0], 3'b000} +: 8]);
    else
      case (word)
        O_IRQST: rd_mux = irq_stat;
        O_FIQST: rd_mux = fiq_stat;
        O_RAW:   rd_mux = raw;
        O_SEL:   rd_mux = sel_q;
        O_ENSET: rd_mux = en_q;
        O_SWSET: rd_mux = soft_q;
        O_PROT:  rd_mux = DW'(prot_q);
        O_VEC:   rd_mux = vec_rd;
        O_DFLT:  rd_mux = vaddr_q[LV_DEF];
        default: rd_mux = '0;
      endcase
  end

  assign bus_rdata = rd_mux;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_q <= '0;
      en_q   <= '0;
      sel_q  <= '0;
      prot_q <= 1'b0;
      lvl_q  <= LW'(LV_IDLE);
      irq_o  <= 1'b0;
      fiq_o  <= 1'b0;
      for (int i = 0; i <= NSLOT; i++) begin
        vaddr_q[i] <= '0;
        prev_q[i]  <= LW'(LV_IDLE);
      end
      for (int i = 0; i < NSLOT; i++) vctl_q[i] <= '0;
    end else begin
      irq_o <= |(irq_stat & pmask[lvl_q]);
      fiq_o <= |fiq_stat;
      if (bus_wr) begin
        if (in_vaddr)     vaddr_q[slot] <= bus_wdata;
        else if (in_vctl) vctl_q[slot]  <= bus_wdata[SW:0];
        else
          case (word)
            O_SEL:   sel_q  <= bus_wdata;
            O_ENSET: en_q   <= en_q | bus_wdata;
            O_ENCLR: en_q   <= en_q & ~bus_wdata;
            O_SWSET: soft_q <= soft_q | bus_wdata;
            O_SWCLR: soft_q <= soft_q & ~bus_wdata;
            O_PROT:  prot_q <= bus_wdata[0];
            O_VEC:   if (lvl_q != LW'(LV_IDLE)) lvl_q <= prev_q[lvl_q];
            O_DFLT:  vaddr_q[LV_DEF] <= bus_wdata;
            default: ;
          endcase
      end else if (vec_read && (hit < lvl_q)) begin
        prev_q[hit] <= lvl_q;
        lvl_q       <= hit;
      end
    end
  end
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk #(
  parameter int DW   = 32,
  parameter int AW   = 12,
  parameter int LW   = 5,
  parameter int IDLE = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic          irq_o,
  input logic          fiq_o,
  input logic [LW-1:0] lvl_q,
  input logic [DW-1:0] en_q,
  input logic [DW-1:0] sel_q,
  input logic [DW-1:0] soft_q
);
  wire vec_wr = bus_wr && (bus_addr[AW-1:2] == (AW-2)'(12));

  a_r1_level_range: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LW'(IDLE));

  a_r9_idle_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_wr && lvl_q == LW'(IDLE)) |=> (lvl_q == LW'(IDLE)));

  a_r9_write_pops_up: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_wr && lvl_q != LW'(IDLE)) |=> (lvl_q > $past(lvl_q)));

  a_r7_only_write_raises: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_wr |=> (lvl_q <= $past(lvl_q)));

  a_r3_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |=> !irq_o);

  a_r4_fiq_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == '0) |=> !fiq_o);

  a_r10_addr0_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == '0) |=>
      ($stable(en_q) && $stable(sel_q) && $stable(soft_q) && $stable(lvl_q)));
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(
  .DW(DW), .AW(AW), .LW(LW), .IDLE(LV_IDLE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .irq_o(irq_o), .fiq_o(fiq_o), .lvl_q(lvl_q),
  .en_q(en_q), .sel_q(sel_q), .soft_q(soft_q)
);

// File: tb/tb_vec_irq_ctrl.sv
`timescale 1ns/1ps
module tb_vec_irq_ctrl;
  localparam logic [63:0] ID_EXP = 64'h5AC3_0010_2907_4E11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata, src_in = '0;
  logic        irq_o, fiq_o;
  int          tests = 0, fails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  vec_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_in(src_in), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; src_in = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 irq_o", 32'(irq_o), 0);
    chk("R1 fiq_o", 32'(fiq_o), 0);
    rd_chk("R1 raw", 12'h008, 0);
    rd_chk("R1 enable", 12'h010, 0);
    rd_chk("R1 slot addr", 12'h104, 0);
    rd_chk("R1 slot ctl", 12'h23C, 0);
    rd_chk("R1 default", 12'h034, 0);
    rd_chk("R8 idle read default", 12'h030, 0);
  endtask

  task automatic t_soft();
    do_reset();
    wr(12'h018, 32'h0000_00F0);
    rd_chk("R2 soft set", 12'h008, 32'h0000_00F0);
    wr(12'h01C, 32'h0000_0030);
    rd_chk("R2 soft clear", 12'h018, 32'h0000_00C0);
    wr(12'h018, 32'h0);
    rd_chk("R2 zero write keeps", 12'h018, 32'h0000_00C0);
    src_in = 32'h0001_0001;
    rd_chk("R2 raw OR", 12'h008, 32'h0001_00C1);
  endtask

  task automatic t_status();
    do_reset();
    wr(12'h010, 32'h0F);
    wr(12'h010, 32'h30);
    wr(12'h014, 32'h05);
    rd_chk("R3 enable set/clear", 12'h010, 32'h3A);
    wr(12'h00C, 32'h30);
    wr(12'h00C, 32'h20);
    rd_chk("R3 select direct", 12'h00C, 32'h20);
    @(negedge clk);
    src_in = 32'h2A;
    #1 chk("R5 irq_o registered, not yet", 32'(irq_o), 0);
    @(negedge clk);
    chk("R5 irq_o after one edge", 32'(irq_o), 1);
    chk("R4 fiq_o", 32'(fiq_o), 1);
    rd_chk("R3 irq status", 12'h000, 32'h0A);
    rd_chk("R3 fiq status", 12'h004, 32'h20);
    src_in = 32'h0A;
    settle();
    chk("R4 fiq_o drops", 32'(fiq_o), 0);
    chk("R5 irq_o stays", 32'(irq_o), 1);
    src_in = 32'h0;
    settle();
    chk("R5 irq_o drops", 32'(irq_o), 0);
    wr(12'h018, 32'h20);
    settle();
    chk("R4 fiq_o from soft bit", 32'(fiq_o), 1);
  endtask

  task automatic t_misc();
    do_reset();
    wr(12'h010, 32'h11);
    wr(12'h00C, 32'h02);
    wr(12'h000, 32'hFFFF_FFFF);
    rd_chk("R10 addr0 write enable", 12'h010, 32'h11);
    rd_chk("R10 addr0 write select", 12'h00C, 32'h02);
    rd_chk("R10 addr0 write soft", 12'h018, 32'h0);
    rd_chk("R10 unmapped read", 12'h040, 32'h0);
    rd_chk("R10 unmapped read hi", 12'h800, 32'h0);
    wr(12'h020, 32'hFFFF_FFFF);
    rd_chk("R12 protection bit", 12'h020, 32'h1);
    wr(12'h020, 32'hFFFF_FFFE);
    rd_chk("R12 protection clear", 12'h020, 32'h0);
    wr(12'hFE0, 32'hFFFF_FFFF);
    for (int k = 0; k < 8; k++)
      rd_chk("R11 id byte", 12'hFE0 + 12'(4 * k), 32'(ID_EXP[8*k +: 8]));
  endtask

  task automatic t_nest();
    do_reset();
    for (int i = 0; i < 4; i++) wr(12'h100 + 12'(4 * i), 32'h1000 + 32'(16 * i));
    wr(12'h034, 32'hDEF0);
    wr(12'h200, 32'h23);
    wr(12'h204, 32'h27);
    wr(12'h208, 32'h09);
    wr(12'h010, 32'h288);
    rd_chk("R6 slot ctl readback", 12'h204, 32'h27);
    rd_chk("R7 slot addr readback", 12'h104, 32'h1010);
    src_in = 32'h200;
    settle();
    chk("R5 idle passes unvectored", 32'(irq_o), 1);
    rd_chk("R6 disabled slot ignored", 12'h030, 32'hDEF0);
    src_in = 32'h280;
    rd_chk("R7 enter level 2", 12'h030, 32'h1020);
    src_in = 32'h200;
    settle();
    chk("R5 level 2 masks unvectored", 32'(irq_o), 0);
    src_in = 32'h208;
    settle();
    chk("R5 level 2 passes slot0 src", 32'(irq_o), 1);
    rd_chk("R7 enter level 1", 12'h030, 32'h1010);
    src_in = 32'h280;
    settle();
    chk("R6 level 1 masks slot1 src", 32'(irq_o), 0);
    rd_chk("R7 no deeper match", 12'h030, 32'h1010);
    settle();
    chk("R7 level kept", 32'(irq_o), 0);
    wr(12'h030, 32'hFFFF_FFFF);
    settle();
    chk("R9 restore to level 2", 32'(irq_o), 1);
    src_in = 32'h200;
    settle();
    chk("R9 level 2 masks", 32'(irq_o), 0);
    wr(12'h030, 32'h0);
    settle();
    chk("R9 restore to idle", 32'(irq_o), 1);
    wr(12'h030, 32'h0);
    settle();
    chk("R9 idle write keeps idle", 32'(irq_o), 1);
    rd_chk("R8 idle default again", 12'h030, 32'hDEF0);
  endtask

  initial begin
    t_reset();
    t_soft();
    t_status();
    t_misc();
    t_nest();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog (all): actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule